// File: doc/BRIEF.md
# PCI Bridge I/O Window Decoder

This block keeps the two I/O window configuration bytes of a PCI-to-PCI bridge, a bottom byte and a top byte. It uses them to decide, for each I/O transaction address seen on either bus, whether the bridge forwards that transaction to the other side. Only 16-bit I/O addressing is supported. The window is aligned to 4 KB, and an address can only fall inside it when its upper 16 bits are zero.

Two control bits modify the window. With the legacy-ISA carve-out bit set, the primary side refuses offsets 400H–FFFH of every 4 KB block, even inside the window. With the legacy-display bit set, two fixed display ranges are recognised in every 1 KB alias. These ranges pass only from the primary side to the secondary side. When the I/O space enable bit is clear, nothing is forwarded. Each request strobe produces a registered decision one clock later.

Top module: `io_window_decoder`

## Requirements
- R1: After reset, both configuration bytes read 00H and `dec_valid` and `dec_fwd` are 0.
- R2: A write with `cfg_sel`=0 loads `cfg_wdata[7:4]` into the bottom nibble register, and `cfg_sel`=1 loads it into the top nibble register. The other register is unchanged. `cfg_rdata` shows the selected register in bits [7:4], and bits [3:0] always read 0H.
- R3: `dec_valid` is 1 in exactly the cycle after a cycle with `req_valid`=1. `dec_fwd` is 0 whenever `dec_valid` is 0.
- R4: Consider a primary request (`req_from_sec`=0) with I/O space enabled and address bits [31:16] zero. It is forwarded when {bottom,000H} ≤ addr[15:0] ≤ {top,FFFH}.
- R5: A primary request whose address bits [31:16] are not all zero is never forwarded.
- R6: When bottom > top, the window is empty. No primary request is forwarded through the window, and every secondary request outside the display ranges is forwarded.
- R7: With `isa_en`=1, a primary request inside the window whose addr[11:10] is not 00 is not forwarded.
- R8: With `vga_en`=1, a primary request is forwarded when its address bits [31:16] are zero and addr[9:0] is in 3B0H–3BBH or 3C0H–3DFH. Bits [15:10] are ignored for this match, and the window and `isa_en` do not affect it.
- R9: With `vga_en`=1, a secondary request (`req_from_sec`=1) that matches those display ranges is not forwarded.
- R10: A secondary request is forwarded when it is not inside the window and not a display-range match. Being inside the window means bits [31:16] are zero and addr[15:0] is within the bounds of R4, and `isa_en` plays no part.
- R11: While `io_space_en`=0, no request on either side is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 1 | 0 selects bottom byte, 1 selects top byte |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected configuration byte |
| io_space_en | input | 1 | I/O space enable command bit |
| isa_en | input | 1 | Legacy ISA carve-out enable |
| vga_en | input | 1 | Legacy display range enable |
| req_valid | input | 1 | Request address strobe |
| req_addr | input | 32 | Request I/O address |
| req_from_sec | input | 1 | 0 when request is seen on primary, 1 on secondary |
| dec_valid | output | 1 | Decision valid pulse, one clock after the strobe |
| dec_fwd | output | 1 | Forward decision |

## Verification
The sweep lands addresses on both edges of every 4 KB nibble against bottom/top pairs that include equal, adjacent and inverted bounds. An off-by-one bound or a non-inclusive compare would then flip a decision at a block edge. The sweep also uses offsets just either side of the 400H carve-out boundary and the display-range edges 3AFH, 3B0H, 3BBH, 3BCH, 3DFH and 3E0H in high aliases. A design that decoded bits [15:10] would miss the aliases, and one that applied the carve-out to the secondary side or to display hits would wrongly block them. Addresses with a single upper bit set catch a decoder that checks only 16 bits. Requests with I/O space disabled, and secondary display hits, catch forwarding in the wrong direction.

// File: rtl/io_window_decoder.sv
module io_window_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_sel,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic        io_space_en,
  input  logic        isa_en,
  input  logic        vga_en,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_from_sec,
  output logic        dec_valid,
  output logic        dec_fwd
);

  logic [3:0] bot_q, top_q;
  logic       upper_zero, in_win, isa_hole, vga_hit, fwd_d;
  logic [9:0] lo10;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bot_q <= 4'h0;
      top_q <= 4'h0;
    end else if (cfg_wr) begin
      if (cfg_sel) top_q <= cfg_wdata[7:4];
      else         bot_q <= cfg_wdata[7:4];
    end

  assign cfg_rdata = {cfg_sel ? top_q : bot_q, 4'h0};

  assign upper_zero = (req_addr[31:16] == 16'h0000);
  assign in_win     = upper_zero && (req_addr[15:12] >= bot_q) && (req_addr[15:12] <= top_q);
  assign isa_hole   = isa_en && (req_addr[11:10] != 2'b00);
  assign lo10       = req_addr[9:0];
  assign vga_hit    = vga_en && upper_zero &&
                      (((lo10 >= 10'h3B0) && (lo10 <= 10'h3BB)) ||
                       ((lo10 >= 10'h3C0) && (lo10 <= 10'h3DF)));

  always_comb begin
    if (!io_space_en)      fwd_d = 1'b0;
    else if (req_from_sec) fwd_d = !in_win && !vga_hit;
    else                   fwd_d = vga_hit || (in_win && !isa_hole);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_fwd   <= 1'b0;
    end else begin
      dec_valid <= req_valid;
      dec_fwd   <= req_valid && fwd_d;
    end

endmodule

// File: rtl/io_window_decoder_chk.sv
module io_window_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        cfg_sel,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_rdata,
  input logic        io_space_en,
  input logic        isa_en,
  input logic        vga_en,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        req_from_sec,
  input logic        dec_valid,
  input logic        dec_fwd
);

  logic vga_rng;
  assign vga_rng = (req_addr[31:16] == 16'h0) &&
                   (((req_addr[9:0] >= 10'h3B0) && (req_addr[9:0] <= 10'h3BB)) ||
                    ((req_addr[9:0] >= 10'h3C0) && (req_addr[9:0] <= 10'h3DF)));

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> dec_valid); // R3
  AST_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !dec_valid); // R3
  AST_FWD_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n) !dec_valid |-> !dec_fwd); // R3
  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_sel != $past(cfg_sel)) || (cfg_rdata == {$past(cfg_wdata[7:4]), 4'h0})); // R2
  AST_UPPER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_from_sec && req_addr[31:16] != 16'h0) |=> !dec_fwd); // R5
  AST_IOSE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !io_space_en) |=> !dec_fwd); // R11
  AST_VGA_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && io_space_en && vga_en && vga_rng && !req_from_sec) |=> dec_fwd); // R8
  AST_VGA_UP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && vga_en && vga_rng && req_from_sec) |=> !dec_fwd); // R9

endmodule

bind io_window_decoder io_window_decoder_chk u_chk (.*);

// File: tb/tb_io_window_decoder.sv
module tb_io_window_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        io_space_en = 1'b0, isa_en = 1'b0, vga_en = 1'b0;
  logic        req_valid = 1'b0, req_from_sec = 1'b0;
  logic [31:0] req_addr = 32'h0;
  logic        dec_valid, dec_fwd;

  int n_vec = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_window_decoder dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ref_fwd(input logic [3:0] b, input logic [3:0] t, input logic [31:0] a,
                                 input bit sec, input bit io, input bit isa, input bit vga);
    bit up, inw, vh;
    int lo;
    up  = (a >> 16) == 0;
    inw = up && (int'(a[15:0]) >= int'(b) * 4096) && (int'(a[15:0]) <= int'(t) * 4096 + 4095);
    lo  = int'(a) % 1024;
    vh  = vga && up && ((lo >= 944 && lo <= 955) || (lo >= 960 && lo <= 991));
    if (!io) return 1'b0;
    if (sec) return !inw && !vh;
    return vh || (inw && !(isa && ((int'(a[11:0]) >= 1024))));
  endfunction

  function automatic string tag_of(input logic [3:0] b, input logic [3:0] t, input logic [31:0] a,
                                   input bit sec, input bit io, input bit isa, input bit vga);
    int lo;
    lo = int'(a[9:0]);
    if (!io) return "R11";
    if (!sec && a[31:16] != 0) return "R5";
    if (vga && ((lo >= 944 && lo <= 955) || (lo >= 960 && lo <= 991))) return sec ? "R9" : "R8";
    if (sec) return "R10";
    if (b > t) return "R6";
    if (isa) return "R7";
    return "R4";
  endfunction

  task automatic wr_cfg(input bit sel, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic apply(input logic [3:0] b, input logic [3:0] t, input logic [31:0] a,
                       input bit sec, input bit io, input bit isa, input bit vga);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_from_sec = sec;
    io_space_en = io; isa_en = isa; vga_en = vga;
    @(posedge clk);
    #1;
    check("R3 valid", int'(dec_valid), 1);
    check(tag_of(b, t, a, sec, io, isa, vga), int'(dec_fwd),
          int'(ref_fwd(b, t, a, sec, io, isa, vga)));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] bl [5];
    logic [11:0] offs [10];
    bl = '{4'h0, 4'h3, 4'h7, 4'h8, 4'hF};
    offs = '{12'h000, 12'h3AF, 12'h3B0, 12'h3BB, 12'h3BC, 12'h3DF, 12'h3E0, 12'h3FF, 12'h400, 12'hFFF};

    #(CLK_PERIOD * 3);
    #1;
    cfg_sel = 1'b0; #1;
    check("R1 bottom", int'(cfg_rdata), 8'h00);
    cfg_sel = 1'b1; #1;
    check("R1 top", int'(cfg_rdata), 8'h00);
    check("R1 valid", int'(dec_valid), 0);
    check("R1 fwd", int'(dec_fwd), 0);
    rst_n = 1'b1;

    wr_cfg(1'b0, 8'hA5);
    cfg_sel = 1'b0; #1;
    check("R2 bottom", int'(cfg_rdata), 8'hA0);
    cfg_sel = 1'b1; #1;
    check("R2 top untouched", int'(cfg_rdata), 8'h00);
    wr_cfg(1'b1, 8'h3F);
    cfg_sel = 1'b1; #1;
    check("R2 top", int'(cfg_rdata), 8'h30);
    cfg_sel = 1'b0; #1;
    check("R2 bottom untouched", int'(cfg_rdata), 8'hA0);

    foreach (bl[i]) foreach (bl[j]) begin
      wr_cfg(1'b0, {bl[i], 4'h9});
      wr_cfg(1'b1, {bl[j], 4'h6});
      @(negedge clk);
      check("R3 idle", int'(dec_valid), 0);
      for (int m = 0; m < 8; m++) begin
        for (int nib = 0; nib < 16; nib++) begin
          for (int k = 0; k < 10; k++) begin
            logic [31:0] a;
            a = {16'h0, 4'(nib), offs[k]};
            apply(bl[i], bl[j], a, m[2], 1'b1, m[0], m[1]);
          end
        end
        apply(bl[i], bl[j], 32'h0001_0000 | 32'(bl[i]) << 12, m[2], 1'b1, m[0], m[1]);
        apply(bl[i], bl[j], 32'h8000_03C0, m[2], 1'b1, m[0], m[1]);
        apply(bl[i], bl[j], {16'h0, bl[i], 12'h3B0}, m[2], 1'b0, m[0], m[1]);
        apply(bl[i], bl[j], {16'h0, bl[j], 12'h000}, m[2], 1'b0, m[0], m[1]);
      end
      req_valid = 1'b0;
    end

    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R3 drop", int'(dec_valid), 0);
    check("R3 fwd low", int'(dec_fwd), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule